// File: doc/BRIEF.md
# Frame-Pattern Grayscale Modulator

This block lets a panel that can only switch each dot on or off show four density levels. Every pixel arrives as a 2-bit level. The two extreme levels map straight to a dark or a lit dot. Each of the two middle levels reads one bit from its own table of sixteen 4x4 on/off matrices. The frame counter picks the matrix, and the low bits of the pixel's row and column pick the cell inside it. Over a sequence of frames, a middle-level pixel is lit in a share of the frames that the host chooses.

The host fills a 64-byte pattern memory through a byte-wide write port. The display path presents one pixel per cycle along with its position and the current frame number. One cycle later it receives a single registered on/off bit. Panel timing and display memory fetch are handled elsewhere.

Top module: `gray_frame_modulator`

## Requirements
- R1: While reset is high, and in the first cycle after reset is released, `dot_valid_o` and `dot_o` are both 0.
- R2: `dot_valid_o` equals `pix_valid_i` from the previous cycle. `dot_o` is 0 in every cycle where `dot_valid_o` is 0.
- R3: A valid pixel with level 0 produces `dot_o` = 0 one cycle later, whatever the pattern memory holds.
- R4: A valid pixel with level 3 produces `dot_o` = 1 one cycle later, whatever the pattern memory holds.
- R5: Level 1 reads table 0, which is bytes 0 to 31. Level 2 reads table 1, which is bytes 32 to 63.
- R6: The matrix index is the frame number modulo 16. The byte read is 32*table + 2*index + bit 1 of the row, so a byte holds either rows 0-1 or rows 2-3 of a matrix.
- R7: Inside the selected byte, the bit read is 4*(bit 0 of the row) + (column modulo 4). Bit 0 is the least significant bit of the byte.
- R8: A byte write made in cycle N is seen by a lookup presented in cycle N+1. A lookup presented in the same cycle as the write still sees the old contents.
- R9: A write replaces all 8 bits of the addressed byte and leaves the other 63 bytes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Host write strobe for the pattern memory |
| wr_addr_i | input | 6 | Byte address of the host write |
| wr_data_i | input | 8 | Byte to write |
| pix_valid_i | input | 1 | A pixel lookup is presented this cycle |
| pix_level_i | input | 2 | Density level of the pixel (0 to 3) |
| pix_col_i | input | COL_W (10) | Pixel column |
| pix_row_i | input | ROW_W (9) | Pixel row |
| frame_i | input | FRAME_W (8) | Frame counter |
| dot_valid_o | output | 1 | `dot_o` carries a result this cycle |
| dot_o | output | 1 | On/off value for the pixel |

## Verification
The memory has no read port, so a wrong address computation or a corrupted byte shows up only as a wrong `dot_o`. It appears one cycle after a lookup that touches the affected cell, at a particular frame modulo 16, row modulo 4 and column modulo 4. For that reason the bench sweeps every level across 32 frames and 8x8 positions, which covers every cell of both tables and the wrap of each modulo. A write-timing fault shows up in the cycle right after a write, when a lookup of the rewritten byte is made back to back with it.

// File: rtl/gsm_pkg.sv
`timescale 1ns/1ps
package gsm_pkg;

  localparam int LEVEL_W = 2;

  typedef enum logic [LEVEL_W-1:0] {
    LVL_OFF  = 2'd0,
    LVL_TAB0 = 2'd1,
    LVL_TAB1 = 2'd2,
    LVL_ON   = 2'd3
  } level_e;

  function automatic int clog2_min1(input int value);
    int r;
    r = $clog2(value);
    return (r < 1) ? 1 : r;
  endfunction

endpackage

// File: rtl/gsm_pattern_ram.sv
`timescale 1ns/1ps
module gsm_pattern_ram #(
  parameter int BYTE_W = 8,
  parameter int DEPTH  = 64,
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [BYTE_W-1:0] rdata_o
);

  // Small distributed memory: synchronous write, asynchronous read.
  logic [BYTE_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/gsm_addr_gen.sv
`timescale 1ns/1ps
module gsm_addr_gen
  import gsm_pkg::*;
#(
  parameter int COL_W     = 10,
  parameter int ROW_W     = 9,
  parameter int FRAME_W   = 8,
  parameter int PAT_DIM   = 4,
  parameter int PAT_COUNT = 16,
  parameter int BYTE_W    = 8,
  parameter int ADDR_W    = 6,
  parameter int BIT_W     = 3
) (
  input  logic [LEVEL_W-1:0] level_i,
  input  logic [COL_W-1:0]   col_i,
  input  logic [ROW_W-1:0]   row_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic [ADDR_W-1:0]  byte_addr_o,
  output logic [BIT_W-1:0]   bit_sel_o
);

  localparam int DIM_W           = $clog2(PAT_DIM);
  localparam int PAT_W           = $clog2(PAT_COUNT);
  localparam int ROWS_PER_BYTE   = BYTE_W / PAT_DIM;
  localparam int BYTES_PER_PAT   = PAT_DIM / ROWS_PER_BYTE;
  localparam int BYTES_PER_TABLE = PAT_COUNT * BYTES_PER_PAT;

  logic [DIM_W-1:0] col_cell;
  logic [DIM_W-1:0] row_cell;
  logic [PAT_W-1:0] pat_idx;
  logic             table_sel;
  int               addr_int;
  int               bit_int;

  assign col_cell  = col_i[DIM_W-1:0];
  assign row_cell  = row_i[DIM_W-1:0];
  assign pat_idx   = frame_i[PAT_W-1:0];
  assign table_sel = (level_e'(level_i) == LVL_TAB1);

  always_comb begin
    addr_int = int'(table_sel) * BYTES_PER_TABLE
             + int'(pat_idx) * BYTES_PER_PAT
             + int'(row_cell) / ROWS_PER_BYTE;
    bit_int  = (int'(row_cell) % ROWS_PER_BYTE) * PAT_DIM + int'(col_cell);
  end

  assign byte_addr_o = ADDR_W'(addr_int);
  assign bit_sel_o   = BIT_W'(bit_int);

endmodule

// File: rtl/gsm_dot_stage.sv
`timescale 1ns/1ps
module gsm_dot_stage
  import gsm_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int BIT_W  = 3
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               valid_i,
  input  logic [LEVEL_W-1:0] level_i,
  input  logic [BYTE_W-1:0]  pattern_byte_i,
  input  logic [BIT_W-1:0]   bit_sel_i,
  output logic               dot_valid_o,
  output logic               dot_o
);

  logic dot_level;
  logic dot_next;
  logic valid_q;
  logic dot_q;

  always_comb begin
    unique case (level_e'(level_i))
      LVL_OFF: dot_level = 1'b0;
      LVL_ON:  dot_level = 1'b1;
      default: dot_level = pattern_byte_i[bit_sel_i];
    endcase
    dot_next = valid_i & dot_level;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      valid_q <= 1'b0;
      dot_q   <= 1'b0;
    end else begin
      valid_q <= valid_i;
      dot_q   <= dot_next;
    end
  end

  assign dot_valid_o = valid_q;
  assign dot_o       = dot_q;

endmodule

// File: rtl/gray_frame_modulator.sv
`timescale 1ns/1ps
module gray_frame_modulator
  import gsm_pkg::*;
#(
  parameter int COL_W       = 10,
  parameter int ROW_W       = 9,
  parameter int FRAME_W     = 8,
  parameter int PAT_DIM     = 4,
  parameter int PAT_COUNT   = 16,
  parameter int TABLE_COUNT = 2,
  parameter int BYTE_W      = 8,
  localparam int MEM_BYTES  = TABLE_COUNT * PAT_COUNT * PAT_DIM * PAT_DIM / BYTE_W,
  localparam int ADDR_W     = clog2_min1(MEM_BYTES)
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [BYTE_W-1:0]  wr_data_i,
  input  logic               pix_valid_i,
  input  logic [1:0]         pix_level_i,
  input  logic [COL_W-1:0]   pix_col_i,
  input  logic [ROW_W-1:0]   pix_row_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               dot_valid_o,
  output logic               dot_o
);

  localparam int BIT_W = clog2_min1(BYTE_W);

  logic [ADDR_W-1:0] rd_addr;
  logic [BIT_W-1:0]  bit_sel;
  logic [BYTE_W-1:0] rd_byte;

  gsm_addr_gen #(
    .COL_W    (COL_W),
    .ROW_W    (ROW_W),
    .FRAME_W  (FRAME_W),
    .PAT_DIM  (PAT_DIM),
    .PAT_COUNT(PAT_COUNT),
    .BYTE_W   (BYTE_W),
    .ADDR_W   (ADDR_W),
    .BIT_W    (BIT_W)
  ) u_addr (
    .level_i    (pix_level_i),
    .col_i      (pix_col_i),
    .row_i      (pix_row_i),
    .frame_i    (frame_i),
    .byte_addr_o(rd_addr),
    .bit_sel_o  (bit_sel)
  );

  gsm_pattern_ram #(
    .BYTE_W(BYTE_W),
    .DEPTH (MEM_BYTES),
    .ADDR_W(ADDR_W)
  ) u_ram (
    .clk_i  (clk_i),
    .we_i   (wr_en_i),
    .waddr_i(wr_addr_i),
    .wdata_i(wr_data_i),
    .raddr_i(rd_addr),
    .rdata_o(rd_byte)
  );

  gsm_dot_stage #(
    .BYTE_W(BYTE_W),
    .BIT_W (BIT_W)
  ) u_dot (
    .clk_i         (clk_i),
    .rst_i         (rst_i),
    .valid_i       (pix_valid_i),
    .level_i       (pix_level_i),
    .pattern_byte_i(rd_byte),
    .bit_sel_i     (bit_sel),
    .dot_valid_o   (dot_valid_o),
    .dot_o         (dot_o)
  );

endmodule

// File: rtl/gsm_checker.sv
`timescale 1ns/1ps
module gsm_checker (
  input logic       clk_i,
  input logic       rst_i,
  input logic       pix_valid_i,
  input logic [1:0] pix_level_i,
  input logic       dot_valid_o,
  input logic       dot_o
);

  assert_reset_clear_R1: assert property (@(posedge clk_i)
    $past(rst_i) |-> (!dot_valid_o && !dot_o));

  assert_valid_follows_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    pix_valid_i |=> dot_valid_o);

  assert_idle_follows_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    !pix_valid_i |=> !dot_valid_o);

  assert_idle_dark_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    !dot_valid_o |-> !dot_o);

  assert_level0_off_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    (pix_valid_i && pix_level_i == 2'd0) |=> !dot_o);

  assert_level3_on_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    (pix_valid_i && pix_level_i == 2'd3) |=> dot_o);

endmodule

bind gray_frame_modulator gsm_checker u_gsm_checker (
  .clk_i      (clk_i),
  .rst_i      (rst_i),
  .pix_valid_i(pix_valid_i),
  .pix_level_i(pix_level_i),
  .dot_valid_o(dot_valid_o),
  .dot_o      (dot_o)
);

// File: tb/gray_frame_modulator_bench.sv
`timescale 1ns/1ps
module gray_frame_modulator_bench;

  logic       clk_i = 1'b0;
  logic       rst_i = 1'b1;
  logic       wr_en_i = 1'b0;
  logic [5:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic       pix_valid_i = 1'b0;
  logic [1:0] pix_level_i = '0;
  logic [9:0] pix_col_i = '0;
  logic [8:0] pix_row_i = '0;
  logic [7:0] frame_i = '0;
  logic       dot_valid_o;
  logic       dot_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] model [64];

  always #4 clk_i = ~clk_i;

  gray_frame_modulator u_gray_frame_modulator (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .pix_valid_i(pix_valid_i),
    .pix_level_i(pix_level_i),
    .pix_col_i  (pix_col_i),
    .pix_row_i  (pix_row_i),
    .frame_i    (frame_i),
    .dot_valid_o(dot_valid_o),
    .dot_o      (dot_o)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic expect_dot(input int lvl, input int col, input int row, input int frm);
    int addr;
    int bitn;
    if (lvl == 0) return 1'b0;
    if (lvl == 3) return 1'b1;
    addr = (lvl - 1) * 32 + (frm % 16) * 2 + ((row >> 1) & 1);
    bitn = (row & 1) * 4 + (col & 3);
    return model[addr][bitn];
  endfunction

  task automatic host_write(input int addr, input int data);
    @(negedge clk_i);
    wr_en_i   = 1'b1;
    wr_addr_i = 6'(addr);
    wr_data_i = 8'(data);
    model[addr] = 8'(data);
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  // One lookup: drive at a falling edge, check at the next falling edge.
  task automatic lookup(input string req, input int lvl, input int col, input int row, input int frm);
    logic exp;
    @(negedge clk_i);
    pix_valid_i = 1'b1;
    pix_level_i = 2'(lvl);
    pix_col_i   = 10'(col);
    pix_row_i   = 9'(row);
    frame_i     = 8'(frm);
    exp = expect_dot(lvl, col, row, frm);
    @(negedge clk_i);
    check(req, dot_valid_o, 1'b1);
    check(req, dot_o, exp);
    pix_valid_i = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state and first cycle after release
    pix_valid_i = 1'b1;
    pix_level_i = 2'd3;
    repeat (3) @(negedge clk_i);
    check("R1", dot_valid_o, 1'b0);
    check("R1", dot_o, 1'b0);
    rst_i = 1'b0;
    pix_valid_i = 1'b0;
    @(negedge clk_i);
    check("R1", dot_valid_o, 1'b0);
    check("R1", dot_o, 1'b0);

    // Load both tables with an arithmetic fill
    for (int a = 0; a < 64; a++) host_write(a, (a * 37 + 11) & 8'hFF);

    // R3 R4 R5 R6 R7: every level, 32 frames, 8x8 positions
    for (int lvl = 0; lvl < 4; lvl++)
      for (int frm = 0; frm < 32; frm++)
        for (int row = 0; row < 8; row++)
          for (int col = 0; col < 8; col++)
            lookup(lvl == 0 ? "R3" : lvl == 3 ? "R4" : "R5_R6_R7", lvl, col, row, frm);

    // R6 R7: large position and frame values wrap by modulo
    lookup("R6_R7", 1, 1023, 511, 255);
    lookup("R6_R7", 2, 1021, 510, 250);
    lookup("R6_R7", 2, 514, 259, 129);

    // R3 R4 with all-ones and all-zeros content
    host_write(0, 8'hFF);
    lookup("R3", 0, 0, 0, 0);
    host_write(32, 8'h00);
    lookup("R4", 3, 0, 0, 0);

    // R2: idle cycle after a lookup
    @(negedge clk_i);
    check("R2", dot_valid_o, 1'b0);
    check("R2", dot_o, 1'b0);

    // R8: write and lookup in the same cycle, then the cycle after
    host_write(40, 8'h00);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = 6'd40; wr_data_i = 8'hFF;
    pix_valid_i = 1'b1; pix_level_i = 2'd2;
    pix_col_i = 10'd2; pix_row_i = 9'd1; frame_i = 8'd4;
    @(negedge clk_i);
    check("R8", dot_o, 1'b0);
    wr_en_i = 1'b0;
    model[40] = 8'hFF;
    @(negedge clk_i);
    check("R8", dot_o, 1'b1);
    pix_valid_i = 1'b0;

    // R9: rewrite one byte, then verify every bit of every byte
    host_write(17, 8'h5A);
    for (int lvl = 1; lvl < 3; lvl++)
      for (int frm = 0; frm < 16; frm++)
        for (int row = 0; row < 4; row++)
          for (int col = 0; col < 4; col++)
            lookup("R9", lvl, col, row, frm);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule